// File: doc/BRIEF.md
# USB IN Endpoint Transmit Controller

This block drives the transmit side of a single USB device IN endpoint whose largest packet is 8 bytes. Software pushes payload bytes into an internal byte queue and steers the endpoint through one control/status word. A simplified serial interface engine then presents IN tokens. For each token the block answers with a data packet, a zero-length packet, a NAK, or a STALL handshake. The engine pulls data bytes one at a time and reports the host handshake (ACK or timeout). The block records completion, underrun and sent-stall events, and it raises one maskable interrupt request.

A state machine with three states handles each token. In IDLE it waits for a token. On a token it decides the answer: STALL if forced, DATA with 8 bytes if at least 8 are queued, DATA with the queued count if the short-packet flag is set, and NAK otherwise. A DATA answer with at least one byte moves to SEND. A zero-length DATA answer moves straight to WAIT_HS. NAK and STALL keep the machine in IDLE. SEND hands out bytes on request. After the last byte it moves to WAIT_HS, and on an underrun it returns to IDLE. In WAIT_HS, an ACK removes the sent bytes and returns to IDLE. A timeout returns to IDLE and keeps the bytes for a retry.

Bus addresses: 0 pushes a byte into the queue (reads 0), 1 is the control/status word, 2 is the interrupt mask (bit 0). Control/status bits: 0 room flag, 1 packet-done, 2 flush, 3 underrun, 4 stall-sent, 5 force-stall, 7 short-packet. Response codes on `resp_kind`: 0 NAK, 1 STALL, 2 DATA.

Top module: `ep_in_tx_ctrl`

## Requirements
- R1: After reset the status word (address 1) reads 0x01, the mask (address 2) reads 1, and `irq` is 0.
- R2: Status bit 0 reads 1 exactly when at least 8 byte slots are free in the queue. Writes to bit 0 have no effect.
- R3: When at least 8 bytes are queued, an IN token gets `resp_kind`=2 with `resp_len`=8 one cycle later, whatever the short flag says. The bytes come out on `tx_byte` in the order they were written.
- R4: When fewer than 8 bytes are queued, stall is off and status bit 7 is 0, an IN token is answered with `resp_kind`=0 (NAK).
- R5: Writing 1 to bit 7 sets it, and writing 0 leaves it unchanged. While it is set, a token sends the queued 0 to 7 bytes. The bit clears when that short packet is ACKed and stays set after a timeout.
- R6: On ACK the sent bytes leave the queue and bit 1 becomes 1. On timeout bit 1 is unchanged and the same bytes are sent on the next token.
- R7: Bits 1, 3 and 4 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R8: Writing 1 to bit 2 empties the queue. Bit 2 always reads 0.
- R9: While bit 5 is 1, every IN token gets `resp_kind`=1 (STALL) and bit 4 becomes 1. Bit 5 reads back what was written.
- R10: A byte request in SEND that finds no queued byte drops `tx_byte_vld`, sets bits 3 and 1, and ends the packet, so the next token is answered fresh from IDLE.
- R11: `irq` equals (bit 1 OR bit 4) AND NOT mask bit 0.
- R12: A byte pushed while 16 bytes are queued is dropped. Bit 6 and bits 31:8 of the status word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 queue, 1 status, 2 mask) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| in_tok | input | 1 | IN token pulse from the engine |
| resp_vld | output | 1 | One-cycle response strobe |
| resp_kind | output | 2 | Response: 0 NAK, 1 STALL, 2 DATA |
| resp_len | output | 4 | Byte count of a DATA response |
| byte_req | input | 1 | Engine asks for the next data byte |
| tx_byte | output | 8 | Data byte for the current request |
| tx_byte_vld | output | 1 | The requested byte exists |
| hs_ack | input | 1 | Host ACK received |
| hs_timeout | input | 1 | No handshake from host |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 16-byte queue and an 8-byte packet limit, so two full packets can be queued. With these values the room flag falls as the ninth byte arrives, a seventeenth byte hits the overflow drop, and an ACK removes only the first packet while the second stays queued. A flush issued in the middle of a packet makes the underrun path reachable. Zero-length, short and retried packets are all driven through the state machine.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
    typedef enum logic [1:0] {
        RESP_NAK   = 2'd0,
        RESP_STALL = 2'd1,
        RESP_DATA  = 2'd2
    } resp_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND    = 2'd1,
        ST_WAIT_HS = 2'd2
    } tx_state_e;

    localparam logic [1:0] ADDR_QUEUE = 2'd0;
    localparam logic [1:0] ADDR_STAT  = 2'd1;
    localparam logic [1:0] ADDR_MASK  = 2'd2;

    localparam int B_ROOM  = 0;
    localparam int B_DONE  = 1;
    localparam int B_FLUSH = 2;
    localparam int B_UNDR  = 3;
    localparam int B_STSNT = 4;
    localparam int B_FSTL  = 5;
    localparam int B_SHORT = 7;
endpackage

// File: rtl/ep_tx_fifo.sv
module ep_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int LW    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          flush,
    input  logic          pop,
    input  logic [LW-1:0] pop_n,
    input  logic [LW-1:0] peek_off,
    output logic [7:0]    peek_byte,
    output logic [CW-1:0] count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok;
    logic [LW-1:0] pop_amt;
    logic [AW-1:0] peek_idx;

    assign push_ok  = push && !flush && (count < CW'(DEPTH));
    assign pop_amt  = !pop ? '0 : ((CW'(pop_n) > count) ? LW'(count) : pop_n);
    assign peek_idx = rd_ptr + AW'(peek_off);
    assign peek_byte = mem[peek_idx];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= wr_ptr;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_amt);
            count  <= count + CW'(push_ok) - CW'(pop_amt);
        end
    end

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/ep_tx_fsm.sv
module ep_tx_fsm
    import ep_tx_pkg::*;
#(
    parameter int PKT_MAX = 8,
    parameter int CW      = 5,
    parameter int LW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_tok,
    input  logic          byte_req,
    input  logic          hs_ack,
    input  logic          hs_timeout,
    input  logic          stall_force,
    input  logic          short_set,
    input  logic [CW-1:0] fifo_cnt,
    output logic          resp_vld,
    output resp_e         resp_kind,
    output logic [LW-1:0] resp_len,
    output logic          byte_vld,
    output logic [LW-1:0] peek_off,
    output logic          pop,
    output logic [LW-1:0] pop_n,
    output logic          ev_done,
    output logic          ev_undr,
    output logic          ev_stall,
    output logic          ev_short_clr
);
    tx_state_e     state, state_d;
    logic [LW-1:0] snd_len, snd_len_d, snd_idx, snd_idx_d;
    logic          snd_short, snd_short_d;
    logic          rv_d;
    resp_e         rk_d;
    logic [LW-1:0] rl_d;
    logic          have_full;

    assign have_full = fifo_cnt >= CW'(PKT_MAX);
    assign byte_vld  = (state == ST_SEND) && (CW'(snd_idx) < fifo_cnt);
    assign peek_off  = snd_idx;
    assign pop_n     = snd_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            snd_len   <= '0;
            snd_idx   <= '0;
            snd_short <= 1'b0;
            resp_vld  <= 1'b0;
            resp_kind <= RESP_NAK;
            resp_len  <= '0;
        end else begin
            state     <= state_d;
            snd_len   <= snd_len_d;
            snd_idx   <= snd_idx_d;
            snd_short <= snd_short_d;
            resp_vld  <= rv_d;
            resp_kind <= rk_d;
            resp_len  <= rl_d;
        end
    end

    always_comb begin
        state_d      = state;
        snd_len_d    = snd_len;
        snd_idx_d    = snd_idx;
        snd_short_d  = snd_short;
        rv_d         = 1'b0;
        rk_d         = resp_kind;
        rl_d         = resp_len;
        pop          = 1'b0;
        ev_done      = 1'b0;
        ev_undr      = 1'b0;
        ev_stall     = 1'b0;
        ev_short_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_tok) begin
                    rv_d      = 1'b1;
                    snd_idx_d = '0;
                    if (stall_force) begin
                        rk_d     = RESP_STALL;
                        rl_d     = '0;
                        ev_stall = 1'b1;
                    end else if (have_full) begin
                        rk_d        = RESP_DATA;
                        rl_d        = LW'(PKT_MAX);
                        snd_len_d   = LW'(PKT_MAX);
                        snd_short_d = 1'b0;
                        state_d     = ST_SEND;
                    end else if (short_set) begin
                        rk_d        = RESP_DATA;
                        rl_d        = LW'(fifo_cnt);
                        snd_len_d   = LW'(fifo_cnt);
                        snd_short_d = 1'b1;
                        state_d     = (fifo_cnt == '0) ? ST_WAIT_HS : ST_SEND;
                    end else begin
                        rk_d = RESP_NAK;
                        rl_d = '0;
                    end
                end
            end
            ST_SEND: begin
                if (byte_req) begin
                    if (byte_vld) begin
                        snd_idx_d = snd_idx + LW'(1);
                        if (snd_idx + LW'(1) == snd_len) state_d = ST_WAIT_HS;
                    end else begin
                        ev_undr = 1'b1;
                        ev_done = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_WAIT_HS: begin
                if (hs_ack) begin
                    pop          = 1'b1;
                    ev_done      = 1'b1;
                    ev_short_clr = snd_short;
                    state_d      = ST_IDLE;
                end else if (hs_timeout) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    p_resp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |=> !resp_vld);
    p_len_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_kind == RESP_DATA) |-> (resp_len <= LW'(PKT_MAX)));
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_tok && stall_force) |=> (resp_vld && resp_kind == RESP_STALL));
    p_nak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_tok && !stall_force && !short_set && fifo_cnt < CW'(PKT_MAX))
        |=> (resp_vld && resp_kind == RESP_NAK));
endmodule

// File: rtl/ep_in_tx_ctrl.sv
module ep_in_tx_ctrl
    import ep_tx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int PKT_MAX = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [1:0]                   bus_addr,
    input  logic [7:0]                   bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic                         in_tok,
    output logic                         resp_vld,
    output logic [1:0]                   resp_kind,
    output logic [$clog2(PKT_MAX+1)-1:0] resp_len,
    input  logic                         byte_req,
    output logic [7:0]                   tx_byte,
    output logic                         tx_byte_vld,
    input  logic                         hs_ack,
    input  logic                         hs_timeout,
    output logic                         irq
);
    localparam int LW = $clog2(PKT_MAX + 1);
    localparam int CW = $clog2(DEPTH + 1);

    logic          f_done, f_undr, f_stsnt, f_fstl, f_short, f_mask;
    logic          stat_wr, push, flush, room;
    logic [CW-1:0] fifo_cnt;
    logic [LW-1:0] peek_off, pop_n;
    logic          pop, ev_done, ev_undr, ev_stall, ev_short_clr;
    resp_e         rk;

    assign stat_wr = bus_wr && (bus_addr == ADDR_STAT);
    assign push    = bus_wr && (bus_addr == ADDR_QUEUE);
    assign flush   = stat_wr && bus_wdata[B_FLUSH];
    assign room    = fifo_cnt <= CW'(DEPTH - PKT_MAX);
    assign irq     = (f_done | f_stsnt) & ~f_mask;
    assign resp_kind = rk;

    ep_tx_fifo #(.DEPTH(DEPTH), .LW(LW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_byte(bus_wdata),
        .flush(flush), .pop(pop), .pop_n(pop_n), .peek_off(peek_off),
        .peek_byte(tx_byte), .count(fifo_cnt)
    );

    ep_tx_fsm #(.PKT_MAX(PKT_MAX), .CW(CW), .LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_tok(in_tok), .byte_req(byte_req),
        .hs_ack(hs_ack), .hs_timeout(hs_timeout), .stall_force(f_fstl),
        .short_set(f_short), .fifo_cnt(fifo_cnt), .resp_vld(resp_vld),
        .resp_kind(rk), .resp_len(resp_len), .byte_vld(tx_byte_vld),
        .peek_off(peek_off), .pop(pop), .pop_n(pop_n), .ev_done(ev_done),
        .ev_undr(ev_undr), .ev_stall(ev_stall), .ev_short_clr(ev_short_clr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_done  <= 1'b0;
            f_undr  <= 1'b0;
            f_stsnt <= 1'b0;
            f_fstl  <= 1'b0;
            f_short <= 1'b0;
            f_mask  <= 1'b1;
        end else begin
            f_done  <= ev_done  | (f_done  & ~(stat_wr & bus_wdata[B_DONE]));
            f_undr  <= ev_undr  | (f_undr  & ~(stat_wr & bus_wdata[B_UNDR]));
            f_stsnt <= ev_stall | (f_stsnt & ~(stat_wr & bus_wdata[B_STSNT]));
            f_short <= (stat_wr & bus_wdata[B_SHORT]) | (f_short & ~ev_short_clr);
            if (stat_wr) f_fstl <= bus_wdata[B_FSTL];
            if (bus_wr && bus_addr == ADDR_MASK) f_mask <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_STAT: begin
                bus_rdata[B_ROOM]  = room;
                bus_rdata[B_DONE]  = f_done;
                bus_rdata[B_UNDR]  = f_undr;
                bus_rdata[B_STSNT] = f_stsnt;
                bus_rdata[B_FSTL]  = f_fstl;
                bus_rdata[B_SHORT] = f_short;
            end
            ADDR_MASK: bus_rdata[0] = f_mask;
            default:   bus_rdata = '0;
        endcase
    end

    p_short_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (f_short && !hs_ack) |=> f_short);
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (f_mask && !(bus_wr && bus_addr == ADDR_MASK)) |=> !irq);
endmodule

// File: tb/test_ep_in_tx_ctrl.sv
`timescale 1ns/1ps
module test_ep_in_tx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd1;
    logic [7:0]  bus_wdata = 8'd0;
    logic [31:0] bus_rdata;
    logic        in_tok = 1'b0;
    logic        resp_vld;
    logic [1:0]  resp_kind;
    logic [3:0]  resp_len;
    logic        byte_req = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_byte_vld;
    logic        hs_ack = 1'b0;
    logic        hs_timeout = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    ep_in_tx_ctrl #(.DEPTH(16), .PKT_MAX(8)) i_ep_in_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_tok(in_tok),
        .resp_vld(resp_vld), .resp_kind(resp_kind), .resp_len(resp_len),
        .byte_req(byte_req), .tx_byte(tx_byte), .tx_byte_vld(tx_byte_vld),
        .hs_ack(hs_ack), .hs_timeout(hs_timeout), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    bit chk_on = 0;
    bit finished = 0;

    logic [7:0] q[$];
    bit m_done, m_undr, m_stsnt, m_fstl, m_short, m_mask = 1;
    int m_len, m_idx;
    bit m_pkt_short;

    function automatic logic [31:0] m_stat();
        logic [31:0] v = '0;
        v[0] = (16 - q.size()) >= 8;
        v[1] = m_done; v[3] = m_undr; v[4] = m_stsnt;
        v[5] = m_fstl; v[7] = m_short;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            if (bus_addr == 2'd1)
                check(bus_rdata == m_stat(), "R7", "per-clock status", bus_rdata, m_stat());
            check(irq == ((m_done | m_stsnt) & ~m_mask), "R11", "per-clock irq",
                  irq, (m_done | m_stsnt) & ~m_mask);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0; bus_addr = 2'd1;
        if (a == 2'd0) begin
            if (q.size() < 16) q.push_back(d);
        end else if (a == 2'd1) begin
            if (d[2]) q.delete();
            if (d[1]) m_done = 0;
            if (d[3]) m_undr = 0;
            if (d[4]) m_stsnt = 0;
            m_fstl = d[5];
            if (d[7]) m_short = 1;
        end else if (a == 2'd2) begin
            m_mask = d[0];
        end
    endtask

    task automatic wbytes(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) wr(2'd0, base + 8'(i));
    endtask

    task automatic token(input string req);
        int ek, el;
        el = 0;
        if (m_fstl) ek = 1;
        else if (q.size() >= 8) begin ek = 2; el = 8; m_pkt_short = 0; end
        else if (m_short) begin ek = 2; el = q.size(); m_pkt_short = 1; end
        else ek = 0;
        in_tok = 1;
        @(posedge clk); #1;
        in_tok = 0;
        if (ek == 1) m_stsnt = 1;
        m_len = el; m_idx = 0;
        check(resp_vld == 1, req, "resp_vld", resp_vld, 1);
        check(resp_kind == 2'(ek), req, "resp_kind", resp_kind, ek);
        if (ek == 2) check(resp_len == 4'(el), req, "resp_len", resp_len, el);
    endtask

    task automatic pull(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            bit have;
            byte_req = 1;
            #1;
            have = m_idx < q.size();
            check(tx_byte_vld == have, req, "tx_byte_vld", tx_byte_vld, have);
            if (have) check(tx_byte == q[m_idx], req, "tx_byte", tx_byte, q[m_idx]);
            @(posedge clk); #1;
            byte_req = 0;
            if (!have) begin
                m_undr = 1; m_done = 1;
                break;
            end
            m_idx++;
        end
    endtask

    task automatic hs(input bit ack);
        if (ack) hs_ack = 1; else hs_timeout = 1;
        @(posedge clk); #1;
        hs_ack = 0; hs_timeout = 0;
        if (ack) begin
            for (int i = 0; i < m_len; i++) if (q.size() > 0) void'(q.pop_front());
            m_done = 1;
            if (m_pkt_short) m_short = 0;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        check(0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1 reset state
        check(bus_rdata == 32'h1, "R1", "status after reset", bus_rdata, 1);
        check(irq == 0, "R1", "irq after reset", irq, 0);
        bus_addr = 2'd2; #0.5;
        check(bus_rdata == 32'h1, "R1", "mask after reset", bus_rdata, 1);
        bus_addr = 2'd1;
        chk_on = 1;
        @(posedge clk); #1;

        // R4 partial without short flag -> NAK
        wbytes(3, 8'hA1);
        token("R4");

        // R12 reserved bits, R2 room flag not writable
        wr(2'd1, 8'h41);
        #0.5;
        check((bus_rdata & 32'hFFFF_FF40) == 0, "R12", "reserved bits", bus_rdata, 0);
        check(bus_rdata[0] == 1, "R2", "room flag unchanged by write", bus_rdata[0], 1);

        // R2 room flag falls at 9 bytes
        wbytes(5, 8'hA4);
        #0.5;
        check(bus_rdata[0] == 1, "R2", "room at 8 queued", bus_rdata[0], 1);
        wbytes(1, 8'hB0);
        #0.5;
        check(bus_rdata[0] == 0, "R2", "no room at 9 queued", bus_rdata[0], 0);
        wbytes(7, 8'hB1);
        wbytes(1, 8'hEE);  // R12 17th byte dropped

        // enable interrupt
        wr(2'd2, 8'h00);

        // R3 full packet, R6 timeout retry then ack
        token("R3");
        pull(8, "R3");
        hs(0);
        #0.5;
        check(bus_rdata[1] == 0, "R6", "done flag after timeout", bus_rdata[1], 0);
        token("R6");
        pull(8, "R6");
        hs(1);
        #0.5;
        check(bus_rdata[1] == 1, "R6", "done flag after ack", bus_rdata[1], 1);
        check(irq == 1, "R11", "irq after ack", irq, 1);

        // R7 write-0 keeps, write-1 clears
        wr(2'd1, 8'h00);
        #0.5;
        check(bus_rdata[1] == 1, "R7", "done kept on write 0", bus_rdata[1], 1);
        wr(2'd1, 8'h02);
        #0.5;
        check(bus_rdata[1] == 0, "R7", "done cleared on write 1", bus_rdata[1], 0);

        // second packet: proves 17th byte dropped (R12)
        token("R12");
        pull(8, "R12");
        hs(1);
        wr(2'd1, 8'h02);
        token("R12");

        // R5 short packet
        wbytes(3, 8'hC0);
        wr(2'd1, 8'h80);
        token("R5");
        pull(3, "R5");
        hs(0);
        #0.5;
        check(bus_rdata[7] == 1, "R5", "short kept after timeout", bus_rdata[7], 1);
        token("R5");
        pull(3, "R5");
        hs(1);
        #0.5;
        check(bus_rdata[7] == 0, "R5", "short cleared after ack", bus_rdata[7], 0);
        // zero-length packet, write 0 no effect
        wr(2'd1, 8'h82);
        wr(2'd1, 8'h00);
        #0.5;
        check(bus_rdata[7] == 1, "R5", "short kept on write 0", bus_rdata[7], 1);
        token("R5");
        hs(1);
        #0.5;
        check(bus_rdata[7] == 0, "R5", "short cleared after zero-length ack", bus_rdata[7], 0);
        wr(2'd1, 8'h02);

        // R9 forced stall
        wbytes(8, 8'hD0);
        wr(2'd1, 8'h20);
        token("R9");
        #0.5;
        check(bus_rdata[4] == 1, "R9", "stall-sent flag", bus_rdata[4], 1);
        check(bus_rdata[5] == 1, "R9", "force-stall reads back", bus_rdata[5], 1);
        // R11 mask gating
        wr(2'd2, 8'h01);
        #0.5;
        check(irq == 0, "R11", "irq masked", irq, 0);
        wr(2'd2, 8'h00);
        #0.5;
        check(irq == 1, "R11", "irq unmasked", irq, 1);
        wr(2'd1, 8'h30);
        wr(2'd1, 8'h00);

        // R8 flush
        wr(2'd1, 8'h04);
        #0.5;
        check(bus_rdata[2] == 0, "R8", "flush reads 0", bus_rdata[2], 0);
        token("R8");

        // R10 underrun mid-packet
        wbytes(8, 8'hE0);
        token("R10");
        pull(3, "R10");
        wr(2'd1, 8'h04);
        pull(1, "R10");
        #0.5;
        check(bus_rdata[3] == 1, "R10", "underrun flag", bus_rdata[3], 1);
        check(bus_rdata[1] == 1, "R10", "done flag on underrun", bus_rdata[1], 1);
        token("R10");
        wr(2'd1, 8'h0A);

        repeat (4) @(posedge clk);
        #1;
        finish_run();
    end
endmodule